// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block keeps a ring of receive descriptors in a small internal memory and fills them in as a MAC receive path reports finished frames. Every frame report carries a byte count (which already counts the four CRC bytes) and a bad-frame flag. The block looks at the descriptor under its current ring index. If hardware owns that descriptor and software has granted at least one credit, the block writes the frame status back into it and gives the descriptor to software by clearing its ownership bit.

Software arms descriptors through a word-wide read/write port into the descriptor memory. A kick register tells hardware how many descriptors it may fill, and a sticky receive-done status bit drives a maskable interrupt. A frame that finds no usable descriptor is dropped and counted. Payload data movement lies outside this block. The only buffer property kept is the 2048-byte slot size, which caps the length that is written back.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset, every descriptor command word reads 0x8000_0000 and every high word reads 0, the credit count equals the ring depth (32), the status byte and the interrupt are 0, and the drop counter is 0.
- R2: An accepted frame rewrites the command word at the current index as follows: bit 31 (ownership) is cleared, bits 30:16 hold the reported length including CRC, and bits 15:0 keep their previous contents. The high word becomes 0x4000_0000 when the frame is bad (bit 30) and 0 otherwise.
- R3: Each accepted frame moves the ring index forward by one. The index wraps from 31 to 0.
- R4: A frame longer than 2048 bytes is written back with length 2048 and with the bad bit (high word bit 30) set. A frame of exactly 2048 bytes is written back unchanged.
- R5: A frame is dropped when the descriptor at the current index has bit 31 clear. A dropped frame leaves every descriptor unchanged, leaves the index where it is, and adds one to the drop counter.
- R6: Each accepted frame reduces the credit count by one. A frame that arrives while the credit count is 0 is dropped, as in R5. A kick write sets the credit count to the written value, limited to 32, and in that cycle it takes priority over the decrement.
- R7: Status bit 0 is set in the cycle after a write-back. A status read returns the bit and clears it, except when a new write-back happens in the same cycle, in which case the bit stays set. Dropped frames do not set the bit.
- R8: The interrupt output is high when any status bit is set whose corresponding mask bit is 0. A mask bit of 1 disables that source.
- R9: A software write with select 0 writes the command word and with select 1 writes the high word. When a software write and a hardware write-back hit the same descriptor in the same cycle, the write-back wins, and it keeps the low 16 bits that the descriptor held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | One-cycle pulse: a frame has completed |
| frm_len_i | input | 16 | Frame byte count including CRC |
| frm_err_i | input | 1 | Frame is bad |
| sw_we_i | input | 1 | Software descriptor write strobe |
| sw_addr_i | input | 5 | Descriptor index for software access |
| sw_sel_i | input | 1 | Word select: 0 command, 1 high |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Selected descriptor word (combinational) |
| kick_we_i | input | 1 | Kick register write strobe |
| kick_val_i | input | 6 | Number of descriptors granted to hardware |
| credit_o | output | 6 | Current credit count |
| stat_rd_i | input | 1 | Status read strobe (read clears) |
| stat_o | output | 8 | Status byte, bit 0 receive-done |
| irq_mask_i | input | 8 | Interrupt mask, 1 disables |
| irq_o | output | 1 | Interrupt request |
| drop_cnt_o | output | 8 | Dropped frame counter |

## Verification
The hardest cases to reach from the ports are the ones where two sources meet in the same cycle: a write-back together with a software write to the same descriptor, a write-back together with a kick, and a write-back together with a status read. Each of these is produced by raising both strobes in a single driven cycle, and only after the ring has been walked into a known index. The wrap from index 31 to 0 and the credit-empty drop only appear after the whole ring has been filled. For that reason the bench first sweeps all 32 descriptors, using lengths computed from the index that cross the 2048-byte limit, and only then re-arms a few descriptors by hand.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned LEN_LSB   = 16;
  localparam int unsigned LEN_FLD_W = 15;
  localparam int unsigned BAD_BIT   = 30;
  localparam int unsigned KEEP_W    = 16;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned STAT_RXDONE = 0;

  typedef struct packed {
    logic [WORD_W-1:0] cmd;
    logic [WORD_W-1:0] hi;
  } desc_wr_t;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_addr_i,
  input  logic              sw_sel_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_rdata_o,
  input  logic              hw_we_i,
  input  logic [IDX_W-1:0]  hw_idx_i,
  input  desc_wr_t          hw_wr_i,
  output logic [WORD_W-1:0] hw_cmd_o
);
  logic [WORD_W-1:0] cmd_q [DEPTH];
  logic [WORD_W-1:0] hi_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmd_q[g] <= WORD_W'(1) << OWN_BIT;
        hi_q[g]  <= '0;
      end else if (hw_we_i && hw_idx_i == IDX_W'(g)) begin
        cmd_q[g] <= hw_wr_i.cmd;   // write-back beats software
        hi_q[g]  <= hw_wr_i.hi;
      end else if (sw_we_i && sw_addr_i == IDX_W'(g)) begin
        if (sw_sel_i) hi_q[g]  <= sw_wdata_i;
        else          cmd_q[g] <= sw_wdata_i;
      end
    end
  end

  assign sw_rdata_o = sw_sel_i ? hi_q[sw_addr_i] : cmd_q[sw_addr_i];
  assign hw_cmd_o   = cmd_q[hw_idx_i];

  logic [IDX_W-1:0] wb_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wb_idx_q <= '0;
    else         wb_idx_q <= hw_idx_i;
  end

  // R2/R9: after a write-back the descriptor belongs to software
  a_r2_own_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_we_i |=> !cmd_q[wb_idx_q][OWN_BIT]);
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned SLOT_BYTES = 2048,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned DROP_W     = 8,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CRED_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              frm_err_i,
  input  logic [WORD_W-1:0] cur_cmd_i,
  input  logic              kick_we_i,
  input  logic [CRED_W-1:0] kick_val_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hw_we_o,
  output desc_wr_t          hw_wr_o,
  output logic [CRED_W-1:0] credit_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              done_set_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [CRED_W-1:0] credit_q;
  logic [DROP_W-1:0] drop_q;
  logic can_take, accept, drop, oversize;
  logic [LEN_W-1:0] len_sel;

  assign can_take = cur_cmd_i[OWN_BIT] && (credit_q != '0);
  assign accept   = frm_valid_i && can_take;
  assign drop     = frm_valid_i && !can_take;
  assign oversize = frm_len_i > LEN_W'(SLOT_BYTES);
  assign len_sel  = oversize ? LEN_W'(SLOT_BYTES) : frm_len_i;

  always_comb begin
    hw_wr_o.cmd = {1'b0, len_sel[LEN_FLD_W-1:0], cur_cmd_i[KEEP_W-1:0]};
    hw_wr_o.hi  = '0;
    hw_wr_o.hi[BAD_BIT] = frm_err_i | oversize;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      credit_q <= CRED_W'(DEPTH);
      drop_q   <= '0;
    end else begin
      if (accept) idx_q <= (idx_q == IDX_W'(DEPTH-1)) ? '0 : idx_q + 1'b1;
      if (kick_we_i)
        credit_q <= (kick_val_i > CRED_W'(DEPTH)) ? CRED_W'(DEPTH) : kick_val_i;
      else if (accept)
        credit_q <= credit_q - 1'b1;
      if (drop) drop_q <= drop_q + 1'b1;
    end
  end

  assign idx_o      = idx_q;
  assign hw_we_o    = accept;
  assign credit_o   = credit_q;
  assign drop_cnt_o = drop_q;
  assign done_set_o = accept;

  a_r6_credit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CRED_W'(DEPTH));
  a_r3_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> idx_q == (($past(idx_q) == IDX_W'(DEPTH-1)) ? '0 : $past(idx_q) + 1'b1));
  a_r5_drop_holds_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> $stable(idx_q) && drop_q == $past(drop_q) + 1'b1);
  a_r6_spend_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !kick_we_i) |=> credit_q == $past(credit_q) - 1'b1);
endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              rd_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    done_q <= 1'b0;
    else if (set_i) done_q <= 1'b1;   // new event beats read-clear
    else if (rd_i)  done_q <= 1'b0;
  end

  always_comb begin
    stat_o = '0;
    stat_o[STAT_RXDONE] = done_q;
  end
  assign irq_o = |(stat_o & ~mask_i);

  a_r7_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> done_q);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rd_i) |=> done_q);
  a_r7_clear_by_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(rd_i));
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned SLOT_BYTES = 2048,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned DROP_W     = 8,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CRED_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              frm_err_i,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_addr_i,
  input  logic              sw_sel_i,
  input  logic [31:0]       sw_wdata_i,
  output logic [31:0]       sw_rdata_o,
  input  logic              kick_we_i,
  input  logic [CRED_W-1:0] kick_val_i,
  output logic [CRED_W-1:0] credit_o,
  input  logic              stat_rd_i,
  output logic [7:0]        stat_o,
  input  logic [7:0]        irq_mask_i,
  output logic              irq_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic [IDX_W-1:0]  idx;
  logic              hw_we, done_set;
  desc_wr_t          hw_wr;
  logic [WORD_W-1:0] cur_cmd;

  rxr_desc_mem #(.DEPTH(DEPTH)) i_mem (
    .clk_i, .rst_ni,
    .sw_we_i, .sw_addr_i, .sw_sel_i, .sw_wdata_i, .sw_rdata_o,
    .hw_we_i(hw_we), .hw_idx_i(idx), .hw_wr_i(hw_wr), .hw_cmd_o(cur_cmd)
  );

  rxr_ctrl #(.DEPTH(DEPTH), .SLOT_BYTES(SLOT_BYTES), .LEN_W(LEN_W), .DROP_W(DROP_W)) i_ctrl (
    .clk_i, .rst_ni,
    .frm_valid_i, .frm_len_i, .frm_err_i,
    .cur_cmd_i(cur_cmd), .kick_we_i, .kick_val_i,
    .idx_o(idx), .hw_we_o(hw_we), .hw_wr_o(hw_wr),
    .credit_o, .drop_cnt_o, .done_set_o(done_set)
  );

  rxr_status i_stat (
    .clk_i, .rst_ni,
    .set_i(done_set), .rd_i(stat_rd_i), .mask_i(irq_mask_i),
    .stat_o, .irq_o
  );
endmodule

// File: tb/test_rx_desc_ring.sv
module test_rx_desc_ring;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rst_ni = 0;
  logic frm_valid = 0, frm_err = 0, sw_we = 0, sw_sel = 0, kick_we = 0, stat_rd = 0;
  logic [15:0] frm_len = '0;
  logic [4:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic [5:0]  kick_val = '0, credit;
  logic [7:0]  stat, irq_mask = '0, drop_cnt;
  logic        irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_ring i_rx_desc_ring (
    .clk_i(clk), .rst_ni(rst_ni),
    .frm_valid_i(frm_valid), .frm_len_i(frm_len), .frm_err_i(frm_err),
    .sw_we_i(sw_we), .sw_addr_i(sw_addr), .sw_sel_i(sw_sel),
    .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata),
    .kick_we_i(kick_we), .kick_val_i(kick_val), .credit_o(credit),
    .stat_rd_i(stat_rd), .stat_o(stat), .irq_mask_i(irq_mask),
    .irq_o(irq), .drop_cnt_o(drop_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sw_write(input int a, input bit sel, input logic [31:0] d);
    sw_addr = a[4:0]; sw_sel = sel; sw_wdata = d; sw_we = 1;
    step();
    sw_we = 0;
  endtask

  task automatic rd_desc(input int a, input bit sel, output logic [31:0] d);
    sw_addr = a[4:0]; sw_sel = sel; #1; d = sw_rdata;
  endtask

  task automatic frame(input int len, input bit err);
    frm_len = len[15:0]; frm_err = err; frm_valid = 1;
    step();
    frm_valid = 0;
  endtask

  task automatic kick(input int v);
    kick_val = v[5:0]; kick_we = 1;
    step();
    kick_we = 0;
  endtask

  task automatic clear_stat();
    stat_rd = 1; step(); stat_rd = 0;
  endtask

  function automatic int low_of(int i);
    return (i * 97 + 5) & 16'hFFFF;
  endfunction
  function automatic int len_of(int i);
    if (i == 10) return 2048;
    if (i == 11) return 2049;
    return 64 + 67 * i;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=expired exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int drops;
    #(3*CLK_PERIOD);
    rst_ni = 1;
    step();

    // R1 reset state
    for (int i = 0; i < N; i++) begin
      rd_desc(i, 0, d); chk("R1 cmd", d, 32'h8000_0000);
      rd_desc(i, 1, d); chk("R1 hi", d, 32'h0);
    end
    chk("R1 credit", {26'b0, credit}, 32);
    chk("R1 stat", {24'b0, stat}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 drop", {24'b0, drop_cnt}, 0);

    // R9 arm every descriptor with its own low bits
    for (int i = 0; i < N; i++) sw_write(i, 0, 32'h8000_0000 | low_of(i));
    for (int i = 0; i < N; i++) begin
      rd_desc(i, 0, d); chk("R9 sw cmd write", d, 32'h8000_0000 | low_of(i));
    end

    // R2 R3 R4 R6 sweep the whole ring
    for (int i = 0; i < N; i++) begin
      int el; bit ee;
      el = (len_of(i) > 2048) ? 2048 : len_of(i);
      ee = (i % 5 == 2) || (len_of(i) > 2048);
      frame(len_of(i), (i % 5 == 2));
      rd_desc(i, 0, d); chk("R2 R4 cmd", d, (el << 16) | low_of(i));
      rd_desc(i, 1, d); chk("R2 R4 hi", d, ee ? 32'h4000_0000 : 0);
      chk("R6 credit", {26'b0, credit}, 32 - (i + 1));
    end
    chk("R7 stat set", {24'b0, stat}, 1);
    irq_mask = 8'h00; #1; chk("R8 irq unmasked", {31'b0, irq}, 1);
    irq_mask = 8'h01; #1; chk("R8 irq masked", {31'b0, irq}, 0);
    irq_mask = 8'hFE; #1; chk("R8 other mask", {31'b0, irq}, 1);
    irq_mask = 8'h00;
    stat_rd = 1; #1; chk("R7 read value", {24'b0, stat}, 1);
    step(); stat_rd = 0;
    chk("R7 cleared", {24'b0, stat}, 0);
    chk("R8 irq low", {31'b0, irq}, 0);

    // R6 empty credit drop
    drops = 0;
    frame(100, 0); drops++;
    chk("R6 drop on zero credit", {24'b0, drop_cnt}, drops);
    chk("R7 drop no status", {24'b0, stat}, 0);

    // R6 kick clamps
    kick(40);
    chk("R6 kick clamp", {26'b0, credit}, 32);

    // R5 not-owned drop, index stays at 0
    frame(200, 1); drops++;
    chk("R5 drop count", {24'b0, drop_cnt}, drops);
    rd_desc(0, 0, d); chk("R5 desc0 untouched", d, (len_of(0) << 16) | low_of(0));
    chk("R5 credit kept", {26'b0, credit}, 32);

    // R3 wrap to 0
    sw_write(0, 0, 32'h8000_0011);
    sw_write(1, 0, 32'h8000_0022);
    frame(300, 0);
    rd_desc(0, 0, d); chk("R3 wrap to 0", d, (300 << 16) | 32'h11);
    frame(301, 1);
    rd_desc(1, 0, d); chk("R3 next 1", d, (301 << 16) | 32'h22);
    rd_desc(1, 1, d); chk("R2 bad hi", d, 32'h4000_0000);
    frame(302, 0); drops++;
    chk("R5 drop at 2", {24'b0, drop_cnt}, drops);
    chk("R6 credit 30", {26'b0, credit}, 30);

    // R9 hw beats sw, R7 set beats read
    clear_stat();
    sw_write(2, 0, 32'h8000_00AB);
    sw_addr = 5'd2; sw_sel = 0; sw_wdata = 32'h8000_1234; sw_we = 1;
    stat_rd = 1;
    frame(100, 0);
    sw_we = 0; stat_rd = 0;
    rd_desc(2, 0, d); chk("R9 hw wins", d, (100 << 16) | 32'hAB);
    chk("R7 set beats read", {24'b0, stat}, 1);
    chk("R6 credit 29", {26'b0, credit}, 29);

    // R6 kick beats decrement
    sw_write(3, 0, 32'h8000_0033);
    kick_val = 6'd5; kick_we = 1;
    frame(64, 0);
    kick_we = 0;
    chk("R6 kick over spend", {26'b0, credit}, 5);
    rd_desc(3, 0, d); chk("R2 desc3", d, (64 << 16) | 32'h33);

    // R6 zero credit with owned descriptor
    kick(0);
    sw_write(4, 0, 32'h8000_0044);
    frame(70, 0); drops++;
    chk("R6 zero-credit drop", {24'b0, drop_cnt}, drops);
    rd_desc(4, 0, d); chk("R6 desc4 untouched", d, 32'h8000_0044);
    kick(1);
    frame(71, 0);
    rd_desc(4, 0, d); chk("R3 resume at 4", d, (71 << 16) | 32'h44);
    chk("R6 credit spent", {26'b0, credit}, 0);

    // R9 high word write
    sw_write(7, 1, 32'hDEAD_0001);
    rd_desc(7, 1, d); chk("R9 sw hi write", d, 32'hDEAD_0001);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule